// File: doc/BRIEF.md
# Priority-Based Spare Repair Controller

This controller keeps an array of reconfigurable cells in service while faults arrive one at a time. A fault request names a faulty cell. The controller looks for a free spare cell in the same section whose size class is large enough. If it finds one, the spare takes over at once. The faulty cell is then handed to an external fault-type test, and the test result decides whether that cell is retired or returns to service.

When no suitable spare exists, a transient fault is left to delayed recovery. A permanent fault draws on a budget of redundant cells: a faulty cell of lowest importance is simply retired, and any other faulty cell takes over the least important live cell that is large enough. From that point the system runs in a degraded mode. When the budget is spent, or no compatible cell remains, the controller halts and accepts no further requests.

A table holds each cell's state, priority and size class. It is loaded on reset from parameters. The array is divided into sections of consecutive cells, and spare search stays inside the faulty cell's section.

Top module: `srp_repair_ctrl`

States: IDLE (accepting), CHECK (reads the faulty entry), SPARE_SCAN (walks the section), TEST (waits for the fault-type result), PRIO_SCAN (walks all cells for the least important candidate), PRIO_DONE (commits the takeover) and HALT (terminal). Transitions:
- IDLE→CHECK on an accepted request.
- CHECK→IDLE when the cell is not working.
- CHECK→SPARE_SCAN when spares remain; CHECK→TEST otherwise.
- SPARE_SCAN→TEST on a hit or at the section end.
- TEST→IDLE, TEST→PRIO_SCAN or TEST→HALT on the test result.
- PRIO_SCAN→PRIO_DONE at the last cell.
- PRIO_DONE→IDLE or PRIO_DONE→HALT.

## Requirements
- R1: After synchronous reset `flt_ready`=1 and `done`, `test_req`, `degraded` and `halted` are 0. The table loads as follows:
  - state encoding is working=0, spare=1, redundant=2, retired=3;
  - spares are cells 15, 16, 21 and 22, and redundant cells are 8, 11, 29 and 32;
  - every other cell starts as working;
  - priority is 1 for redundant cells, 0 when index mod 5 is 0, and 2 + (index mod 12) otherwise;
  - size class is (index*5) mod 8.
- R2: A request is accepted only when `flt_ready` and `flt_valid` are both 1. A request with an index of 36 or more, or naming a cell that is not working, produces no `test_req` and no `done`, and `flt_ready` returns to 1.
- R3: From acceptance until `done`, `flt_ready` is 0, and requests presented in that time have no effect.
- R4: An eligible spare is in the same section (index/9) as the faulty cell, is in the spare state, and has a size class at least that of the faulty cell. The lowest eligible index is taken.
- R5: When a spare is found it takes over before the test. `test_req` is then raised with `test_idx` equal to the faulty index, and `done_repl_idx` reports the spare.
- R6: With a spare in place, `test_transient`=0 (permanent) retires the faulty cell with `done_retired`=1. `test_transient`=1 (transient) keeps the faulty cell working, returns the spare to the free spare pool, and gives `done_retired`=0.
- R7: With no eligible spare and a transient result, `done` reports `done_repl_idx` equal to the faulty index and `done_retired`=0.
- R8: With no eligible spare, a permanent result, a nonzero redundant budget and faulty priority 0, the faulty cell is retired and `done_repl_idx` equals the faulty index.
- R9: With no eligible spare, a permanent result, a nonzero budget and a nonzero faulty priority, the controller scans all cells. The chosen cell is the live (working or redundant) cell, other than the faulty one, with size class at least the faulty cell's and the lowest priority, ties going to the lowest index. The chosen cell becomes working with the faulty priority, the faulty cell is retired (`done_retired`=1), and the budget, initially 4, drops by one.
- R10: `degraded` rises with the first R9 takeover and stays high until reset.
- R11: A permanent fault with no eligible spare and either a zero budget or no R9 candidate retires the faulty cell and reports `done_repl_idx` equal to the faulty index. It also sets `halted`, which keeps `flt_ready` at 0 until reset.
- R12: `done` is a single-cycle pulse, and `done_flt_idx` carries the faulty index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flt_valid | input | 1 | Fault request |
| flt_idx | input | 6 | Index of the faulty cell |
| flt_ready | output | 1 | Controller idle and accepting |
| test_req | output | 1 | Fault-type test requested |
| test_idx | output | 6 | Cell under test |
| test_done | input | 1 | Test result valid |
| test_transient | input | 1 | 1 transient, 0 permanent |
| done | output | 1 | Repair complete pulse |
| done_flt_idx | output | 6 | Faulty index of the completed repair |
| done_repl_idx | output | 6 | Replacement index, or the faulty index when none |
| done_retired | output | 1 | Faulty cell was retired |
| degraded | output | 1 | A live cell has been repurposed |
| halted | output | 1 | No further correction possible |

## Verification
The hardest path to reach is a halt caused by budget exhaustion. Reaching it needs several permanent faults in sections whose spares are used up or too small, each followed by a takeover of a live cell. The bench drives long random fault sequences with mostly permanent results from a fixed seed until its model reports a halt. It repeats this over several runs after reset, alongside directed cases that hit a section spare, a transient revert, a priority-0 retirement and ignored requests.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int PRIO_W = 4;
    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        CS_WORK    = 2'd0,
        CS_SPARE   = 2'd1,
        CS_REDUND  = 2'd2,
        CS_RETIRED = 2'd3
    } cell_state_e;

    function automatic logic [PRIO_W-1:0] init_prio(input int i, input logic red);
        if (red) return PRIO_W'(1);
        if (i % 5 == 0) return PRIO_W'(0);
        return PRIO_W'(2 + (i % 12));
    endfunction

    function automatic logic [SIZE_W-1:0] init_size(input int i);
        return SIZE_W'((i * 5) % (1 << SIZE_W));
    endfunction
endpackage

// File: rtl/srp_cell_table.sv
module srp_cell_table
    import srp_pkg::*;
#(
    parameter int N = 36,
    parameter int IDX_W = 6,
    parameter logic [N-1:0] SPARE_MASK = '0,
    parameter logic [N-1:0] REDUND_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     ra_idx,
    output cell_state_e          ra_state,
    output logic [PRIO_W-1:0]    ra_prio,
    output logic [SIZE_W-1:0]    ra_size,
    input  logic [IDX_W-1:0]     rb_idx,
    output cell_state_e          rb_state,
    output logic [PRIO_W-1:0]    rb_prio,
    output logic [SIZE_W-1:0]    rb_size,
    input  logic                 wa_en,
    input  logic [IDX_W-1:0]     wa_idx,
    input  cell_state_e          wa_state,
    input  logic                 wa_prio_en,
    input  logic [PRIO_W-1:0]    wa_prio,
    input  logic                 wb_en,
    input  logic [IDX_W-1:0]     wb_idx,
    input  cell_state_e          wb_state
);
    localparam logic [IDX_W:0] N_LIM = (IDX_W+1)'(N);

    cell_state_e         st_q   [N];
    logic [PRIO_W-1:0]   prio_q [N];
    logic [SIZE_W-1:0]   size_c [N];

    for (genvar g = 0; g < N; g++) begin : g_size
        assign size_c[g] = init_size(g);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                st_q[i]   <= SPARE_MASK[i] ? CS_SPARE : (REDUND_MASK[i] ? CS_REDUND : CS_WORK);
                prio_q[i] <= init_prio(i, REDUND_MASK[i]);
            end
        end else begin
            if (wa_en && ({1'b0, wa_idx} < N_LIM)) begin
                st_q[wa_idx] <= wa_state;
                if (wa_prio_en) prio_q[wa_idx] <= wa_prio;
            end
            if (wb_en && ({1'b0, wb_idx} < N_LIM)) st_q[wb_idx] <= wb_state;
        end
    end

    always_comb begin
        ra_state = CS_RETIRED; ra_prio = '0; ra_size = '0;
        rb_state = CS_RETIRED; rb_prio = '0; rb_size = '0;
        if ({1'b0, ra_idx} < N_LIM) begin
            ra_state = st_q[ra_idx]; ra_prio = prio_q[ra_idx]; ra_size = size_c[ra_idx];
        end
        if ({1'b0, rb_idx} < N_LIM) begin
            rb_state = st_q[rb_idx]; rb_prio = prio_q[rb_idx]; rb_size = size_c[rb_idx];
        end
    end

    // R9: both write ports never target the same cell in one cycle
    assert_write_ports_disjoint_R9: assert property (@(posedge clk) disable iff (rst)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));
endmodule

// File: rtl/srp_counters.sv
module srp_counters #(
    parameter int N = 36,
    parameter logic [N-1:0] SPARE_MASK = '0,
    parameter logic [N-1:0] REDUND_MASK = '0,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spare_dec,
    input  logic             spare_inc,
    input  logic             red_dec,
    output logic [CNT_W-1:0] spare_cnt,
    output logic [CNT_W-1:0] red_cnt
);
    function automatic int ones(input logic [N-1:0] v);
        int c;
        c = 0;
        for (int i = 0; i < N; i++) c = c + (v[i] ? 1 : 0);
        return c;
    endfunction

    localparam logic [CNT_W-1:0] SPARE0 = CNT_W'(ones(SPARE_MASK));
    localparam logic [CNT_W-1:0] RED0   = CNT_W'(ones(REDUND_MASK));

    always_ff @(posedge clk) begin
        if (rst) begin
            spare_cnt <= SPARE0;
            red_cnt   <= RED0;
        end else begin
            if (spare_dec && !spare_inc) spare_cnt <= spare_cnt - CNT_W'(1);
            else if (spare_inc && !spare_dec) spare_cnt <= spare_cnt + CNT_W'(1);
            if (red_dec) red_cnt <= red_cnt - CNT_W'(1);
        end
    end

    assert_no_spare_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        spare_dec |-> (spare_cnt != '0));
    assert_no_budget_underflow_R9: assert property (@(posedge clk) disable iff (rst)
        red_dec |-> (red_cnt != '0));
endmodule

// File: rtl/srp_min_tracker.sv
module srp_min_tracker #(
    parameter int IDX_W = 6,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cand,
    input  logic [IDX_W-1:0]  cand_idx,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              have,
    output logic [IDX_W-1:0]  best_idx,
    output logic [PRIO_W-1:0] best_prio
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have      <= 1'b0;
            best_idx  <= '0;
            best_prio <= '0;
        end else if (cand && (!have || cand_prio < best_prio)) begin
            have      <= 1'b1;
            best_idx  <= cand_idx;
            best_prio <= cand_prio;
        end
    end

    // R9: once a candidate is held it is only dropped by clear
    assert_best_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (have && !clear) |=> have);
    // R9: a held best never gets worse without clear
    assert_best_monotone_R9: assert property (@(posedge clk) disable iff (rst)
        (have && !clear) |=> (best_prio <= $past(best_prio)));
endmodule

// File: rtl/srp_repair_ctrl.sv
module srp_repair_ctrl
    import srp_pkg::*;
#(
    parameter int N = 36,
    parameter int TILE = 9,
    parameter logic [N-1:0] SPARE_MASK  = N'(36'h0_0061_8000),
    parameter logic [N-1:0] REDUND_MASK = N'(36'h1_2000_0900),
    localparam int IDX_W = $clog2(N),
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flt_valid,
    input  logic [IDX_W-1:0] flt_idx,
    output logic             flt_ready,
    output logic             test_req,
    output logic [IDX_W-1:0] test_idx,
    input  logic             test_done,
    input  logic             test_transient,
    output logic             done,
    output logic [IDX_W-1:0] done_flt_idx,
    output logic [IDX_W-1:0] done_repl_idx,
    output logic             done_retired,
    output logic             degraded,
    output logic             halted
);
    localparam logic [IDX_W:0]   N_LIM = (IDX_W+1)'(N);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N - 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_SPARE_SCAN, ST_TEST, ST_PRIO_SCAN, ST_PRIO_DONE, ST_HALT
    } fsm_e;

    fsm_e state_q, state_d;

    logic [IDX_W-1:0]  fidx_q, ptr_q, scan_end_q, repl_q;
    logic [PRIO_W-1:0] fprio_q;
    logic [SIZE_W-1:0] fsize_q;
    logic              found_q;

    cell_state_e       ra_state, rb_state, wa_state, wb_state;
    logic [PRIO_W-1:0] ra_prio, rb_prio, wa_prio;
    logic [SIZE_W-1:0] ra_size, rb_size;
    logic              wa_en, wa_prio_en, wb_en;
    logic [IDX_W-1:0]  wa_idx, wb_idx;

    logic              spare_dec, spare_inc, red_dec;
    logic [CNT_W-1:0]  spare_cnt, red_cnt;

    logic              trk_clear, trk_cand, trk_have;
    logic [IDX_W-1:0]  trk_best;
    logic [PRIO_W-1:0] trk_best_prio;

    logic              done_set, done_ret_d, set_halt, set_deg, accept, spare_hit;
    logic [IDX_W-1:0]  done_repl_d, sec_base, sec_end;
    int                sec_b_i, sec_e_i;

    srp_cell_table #(.N(N), .IDX_W(IDX_W), .SPARE_MASK(SPARE_MASK), .REDUND_MASK(REDUND_MASK)) table_i (
        .clk(clk), .rst(rst),
        .ra_idx(ptr_q), .ra_state(ra_state), .ra_prio(ra_prio), .ra_size(ra_size),
        .rb_idx(fidx_q), .rb_state(rb_state), .rb_prio(rb_prio), .rb_size(rb_size),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_prio_en(wa_prio_en), .wa_prio(wa_prio),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_state(wb_state)
    );

    srp_counters #(.N(N), .SPARE_MASK(SPARE_MASK), .REDUND_MASK(REDUND_MASK)) cnt_i (
        .clk(clk), .rst(rst), .spare_dec(spare_dec), .spare_inc(spare_inc), .red_dec(red_dec),
        .spare_cnt(spare_cnt), .red_cnt(red_cnt)
    );

    srp_min_tracker #(.IDX_W(IDX_W), .PRIO_W(PRIO_W)) trk_i (
        .clk(clk), .rst(rst), .clear(trk_clear), .cand(trk_cand), .cand_idx(ptr_q),
        .cand_prio(ra_prio), .have(trk_have), .best_idx(trk_best), .best_prio(trk_best_prio)
    );

    always_comb begin
        sec_b_i = (int'(fidx_q) / TILE) * TILE;
        sec_e_i = sec_b_i + TILE - 1;
        if (sec_e_i > N - 1) sec_e_i = N - 1;
        sec_base = IDX_W'(sec_b_i);
        sec_end  = IDX_W'(sec_e_i);
    end

    assign flt_ready = (state_q == ST_IDLE);
    assign test_req  = (state_q == ST_TEST);
    assign test_idx  = fidx_q;
    assign accept    = flt_ready && flt_valid && ({1'b0, flt_idx} < N_LIM);
    assign spare_hit = (ra_state == CS_SPARE) && (ra_size >= fsize_q);

    always_comb begin
        state_d = state_q;
        wa_en = 1'b0; wa_idx = ptr_q; wa_state = CS_WORK; wa_prio_en = 1'b0; wa_prio = fprio_q;
        wb_en = 1'b0; wb_idx = fidx_q; wb_state = CS_RETIRED;
        spare_dec = 1'b0; spare_inc = 1'b0; red_dec = 1'b0;
        trk_clear = 1'b0; trk_cand = 1'b0;
        done_set = 1'b0; done_repl_d = fidx_q; done_ret_d = 1'b0;
        set_halt = 1'b0; set_deg = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_CHECK;
            ST_CHECK: begin
                if (rb_state != CS_WORK)      state_d = ST_IDLE;
                else if (spare_cnt != '0)     state_d = ST_SPARE_SCAN;
                else                          state_d = ST_TEST;
            end
            ST_SPARE_SCAN: begin
                if (spare_hit) begin
                    wa_en = 1'b1; wa_prio_en = 1'b1;
                    spare_dec = 1'b1;
                    state_d = ST_TEST;
                end else if (ptr_q == scan_end_q) begin
                    state_d = ST_TEST;
                end
            end
            ST_TEST: if (test_done) begin
                if (found_q) begin
                    done_set = 1'b1; done_repl_d = repl_q; state_d = ST_IDLE;
                    if (test_transient) begin
                        wa_en = 1'b1; wa_idx = repl_q; wa_state = CS_SPARE; spare_inc = 1'b1;
                    end else begin
                        wb_en = 1'b1; done_ret_d = 1'b1;
                    end
                end else if (test_transient) begin
                    done_set = 1'b1; state_d = ST_IDLE;
                end else if (red_cnt == '0) begin
                    wb_en = 1'b1; done_set = 1'b1; done_ret_d = 1'b1; set_halt = 1'b1;
                    state_d = ST_HALT;
                end else if (fprio_q == '0) begin
                    wb_en = 1'b1; done_set = 1'b1; done_ret_d = 1'b1; state_d = ST_IDLE;
                end else begin
                    trk_clear = 1'b1; state_d = ST_PRIO_SCAN;
                end
            end
            ST_PRIO_SCAN: begin
                trk_cand = ((ra_state == CS_WORK) || (ra_state == CS_REDUND)) &&
                           (ptr_q != fidx_q) && (ra_size >= fsize_q);
                if (ptr_q == LAST) state_d = ST_PRIO_DONE;
            end
            ST_PRIO_DONE: begin
                wb_en = 1'b1; done_set = 1'b1; done_ret_d = 1'b1;
                if (trk_have) begin
                    wa_en = 1'b1; wa_idx = trk_best; wa_prio_en = 1'b1;
                    red_dec = 1'b1; set_deg = 1'b1; done_repl_d = trk_best;
                    state_d = ST_IDLE;
                end else begin
                    set_halt = 1'b1; state_d = ST_HALT;
                end
            end
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fidx_q <= '0; ptr_q <= '0; scan_end_q <= '0; repl_q <= '0;
            fprio_q <= '0; fsize_q <= '0; found_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) fidx_q <= flt_idx;
                ST_CHECK: begin
                    fprio_q <= rb_prio; fsize_q <= rb_size;
                    ptr_q <= sec_base; scan_end_q <= sec_end; found_q <= 1'b0;
                end
                ST_SPARE_SCAN: begin
                    if (spare_hit) begin
                        found_q <= 1'b1; repl_q <= ptr_q;
                    end else if (ptr_q != scan_end_q) begin
                        ptr_q <= ptr_q + IDX_W'(1);
                    end
                end
                ST_TEST:      ptr_q <= '0;
                ST_PRIO_SCAN: if (ptr_q != LAST) ptr_q <= ptr_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0; done_flt_idx <= '0; done_repl_idx <= '0; done_retired <= 1'b0;
            degraded <= 1'b0; halted <= 1'b0;
        end else begin
            done <= done_set;
            if (done_set) begin
                done_flt_idx  <= fidx_q;
                done_repl_idx <= done_repl_d;
                done_retired  <= done_ret_d;
            end
            if (set_deg)  degraded <= 1'b1;
            if (set_halt) halted   <= 1'b1;
        end
    end

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst) halted |=> halted);
    assert_halt_blocks_R11: assert property (@(posedge clk) disable iff (rst) halted |-> !flt_ready);
    assert_degraded_sticky_R10: assert property (@(posedge clk) disable iff (rst) degraded |=> degraded);
    assert_busy_not_ready_R3: assert property (@(posedge clk) disable iff (rst) test_req |-> !flt_ready);
    assert_takeover_retires_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(degraded) |-> (done && done_retired));
endmodule

// File: tb/srp_repair_ctrl_tb.sv
module srp_repair_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 36;
    localparam int TILE = 9;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flt_valid = 1'b0;
    logic [5:0] flt_idx = '0;
    logic test_done = 1'b0;
    logic test_transient = 1'b0;
    logic flt_ready, test_req, done, done_retired, degraded, halted;
    logic [5:0] test_idx, done_flt_idx, done_repl_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int m_state [N];
    int m_prio  [N];
    int m_size  [N];
    int m_red, m_deg, m_halt;

    always #(CLK_PERIOD/2) clk = ~clk;

    srp_repair_ctrl dut_i (
        .clk(clk), .rst(rst), .flt_valid(flt_valid), .flt_idx(flt_idx), .flt_ready(flt_ready),
        .test_req(test_req), .test_idx(test_idx), .test_done(test_done),
        .test_transient(test_transient), .done(done), .done_flt_idx(done_flt_idx),
        .done_repl_idx(done_repl_idx), .done_retired(done_retired),
        .degraded(degraded), .halted(halted)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit is_spare0(input int i);
        return (i == 15) || (i == 16) || (i == 21) || (i == 22);
    endfunction
    function automatic bit is_red0(input int i);
        return (i == 8) || (i == 11) || (i == 29) || (i == 32);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_state[i] = is_spare0(i) ? 1 : (is_red0(i) ? 2 : 0);
            m_prio[i]  = is_red0(i) ? 1 : ((i % 5 == 0) ? 0 : 2 + (i % 12));
            m_size[i]  = (i * 5) % 8;
        end
        m_red = 4; m_deg = 0; m_halt = 0;
    endtask

    // Returns ign=1 when ignored; otherwise the expected replacement, retired flag and tag
    task automatic model_apply(input int idx, input bit trans, output bit ign,
                               output int repl, output bit ret, output string tag);
        int b, e, sp, best;
        ign = 0; repl = idx; ret = 0; tag = "R7";
        if (idx >= N || m_state[idx] != 0) begin ign = 1; tag = "R2"; return; end
        b = (idx / TILE) * TILE; e = b + TILE - 1; if (e > N - 1) e = N - 1;
        sp = -1;
        for (int j = b; j <= e; j++)
            if (sp < 0 && m_state[j] == 1 && m_size[j] >= m_size[idx]) sp = j;
        if (sp >= 0) begin
            repl = sp; m_prio[sp] = m_prio[idx];
            if (trans) begin tag = "R6"; end
            else begin m_state[sp] = 0; m_state[idx] = 3; ret = 1; tag = "R4"; end
            return;
        end
        if (trans) return;
        ret = 1;
        if (m_red == 0) begin m_state[idx] = 3; m_halt = 1; tag = "R11"; return; end
        if (m_prio[idx] == 0) begin m_state[idx] = 3; tag = "R8"; return; end
        best = -1;
        for (int j = 0; j < N; j++)
            if ((m_state[j] == 0 || m_state[j] == 2) && j != idx && m_size[j] >= m_size[idx])
                if (best < 0 || m_prio[j] < m_prio[best]) best = j;
        m_state[idx] = 3;
        if (best < 0) begin m_halt = 1; tag = "R11"; return; end
        m_state[best] = 0; m_prio[best] = m_prio[idx];
        m_red = m_red - 1; m_deg = 1; repl = best; tag = "R9";
    endtask

    task automatic do_reset();
        rst = 1'b1; flt_valid = 1'b0; test_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        chk(flt_ready == 1'b1, "R1", "ready after reset", flt_ready, 1);
        chk(done == 1'b0 && test_req == 1'b0, "R1", "done/test_req after reset", done, 0);
        chk(degraded == 1'b0 && halted == 1'b0, "R1", "flags after reset", {degraded, halted}, 0);
    endtask

    task automatic do_fault(input int idx, input bit trans, input int tdelay);
        bit ign, ret;
        int repl, n;
        string tag;
        model_apply(idx, trans, ign, repl, ret, tag);
        n = 0;
        while (!flt_ready && n < 100) begin @(negedge clk); n++; end
        flt_valid = 1'b1; flt_idx = 6'(idx);
        @(negedge clk);
        flt_valid = 1'b0;
        if (ign) begin
            n = 0;
            for (int k = 0; k < 15; k++) begin
                if (test_req || done) n++;
                @(negedge clk);
            end
            chk(n == 0, "R2", "ignored request activity", n, 0);
            chk(flt_ready == 1'b1, "R2", "ready after ignored", flt_ready, 1);
            return;
        end
        n = 0;
        while (!test_req && n < 60) begin @(negedge clk); n++; end
        chk(test_req == 1'b1, "R5", "test_req raised", test_req, 1);
        chk(test_idx == 6'(idx), "R5", "test_idx", test_idx, idx);
        chk(flt_ready == 1'b0, "R3", "ready low while busy", flt_ready, 0);
        flt_valid = 1'b1; flt_idx = 6'((idx + 1) % N);
        @(negedge clk);
        flt_valid = 1'b0;
        repeat (tdelay) @(negedge clk);
        test_done = 1'b1; test_transient = trans;
        @(negedge clk);
        test_done = 1'b0;
        n = 0;
        while (!done && n < 200) begin @(negedge clk); n++; end
        chk(done == 1'b1, tag, "done seen", done, 1);
        chk(done_flt_idx == 6'(idx), "R12", "done_flt_idx", done_flt_idx, idx);
        chk(done_repl_idx == 6'(repl), tag, "done_repl_idx", done_repl_idx, repl);
        chk(done_retired == ret, tag, "done_retired", done_retired, ret);
        chk(degraded == m_deg[0], "R10", "degraded", degraded, m_deg);
        chk(halted == m_halt[0], "R11", "halted", halted, m_halt);
        @(negedge clk);
        chk(done == 1'b0, "R12", "done single cycle", done, 0);
        if (m_halt != 0) begin
            flt_valid = 1'b1; flt_idx = 6'(idx);
            repeat (4) @(negedge clk);
            flt_valid = 1'b0;
            chk(flt_ready == 1'b0 && test_req == 1'b0, "R11", "halt blocks requests",
                {flt_ready, test_req}, 0);
        end else begin
            chk(test_req == 1'b0, "R3", "busy-time request dropped", test_req, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        do_fault(10, 1'b0, 0);
        do_fault(18, 1'b1, 2);
        do_fault(18, 1'b0, 1);
        do_fault(15, 1'b0, 0);
        do_fault(40, 1'b0, 0);
        do_fault(0, 1'b0, 0);
        do_fault(1, 1'b1, 0);
        do_fault(1, 1'b0, 3);
        do_fault(2, 1'b0, 0);
        for (int run = 0; run < 6; run++) begin
            do_reset();
            for (int f = 0; f < 80 && m_halt == 0; f++)
                do_fault(int'($urandom_range(0, 37)), ($urandom_range(0, 3) == 0),
                         int'($urandom_range(0, 3)));
            chk(m_halt == 1, "R11", "run reached halt", m_halt, 1);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule